// File: doc/BRIEF.md
# Load-Use Stall Interlock

This block sits at the front of a five-stage in-order pipeline. It owns four registers: the program counter, the next-PC and instruction registers between fetch and decode, and the instruction register of the execute stage. On every cycle it checks whether the instruction now in execute is a memory load whose destination is read by the instruction now in decode. A load's data only arrives at the end of the memory stage, so forwarding cannot cover that case.

When that hazard is seen, the block freezes the program counter and both fetch/decode registers for one edge. At the same edge it loads an all-zero word, a no-op, into the execute-stage instruction register. The all-zero opcode is not a load, so the hazard disappears on the next cycle by itself and the held instruction moves on. Without a hazard, all four registers take their normal next values from the surrounding pipeline. The later stages are outside this block and keep advancing during a stall.

Instruction fields are numbered from the most significant bit. The opcode is bits 31:26. The first source register is bits 25:21. The second source register is bits 20:16, and the same field holds a load's destination.

Top module: `ldi_interlock`

## Requirements
- R1: `stall_o` is high exactly when the execute instruction has opcode 6'b100011 (load) in bits 31:26 and its bits 20:16 equal bits 25:21 or bits 20:16 of the decode instruction.
- R2: At a clock edge where `stall_o` is high, `pc_o`, `fd_npc_o` and `fd_ir_o` keep their values and ignore their next-value inputs.
- R3: At a clock edge where `stall_o` is high, `ex_ir_o` becomes 32'h0000_0000.
- R4: At a clock edge where `stall_o` is low, `pc_o`, `fd_npc_o` and `fd_ir_o` take `pc_next_i`, `fd_npc_next_i` and `fd_ir_next_i`, and `ex_ir_o` takes the previous `fd_ir_o`.
- R5: A stall lasts one cycle: the cycle after `stall_o` was high has `stall_o` low, and the held decode instruction then moves into execute.
- R6: An execute instruction whose opcode is not 6'b100011 never causes a stall, even when its bits 20:16 match a decode source field.
- R7: A synchronous active-high reset clears all four registers to zero and leaves `stall_o` low, including when it arrives during a stall.
- R8: A match on either decode source field alone is enough to stall. A load destination that equals only bits 15:11 of the decode instruction does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| pc_next_i | input | ADDR_W | Normal next program counter |
| fd_npc_next_i | input | ADDR_W | Normal next value of the fetch/decode next-PC register |
| fd_ir_next_i | input | 32 | Fetched instruction for the fetch/decode register |
| pc_o | output | ADDR_W | Registered program counter |
| fd_npc_o | output | ADDR_W | Fetch/decode next-PC register |
| fd_ir_o | output | 32 | Decode-stage instruction |
| ex_ir_o | output | 32 | Execute-stage instruction |
| stall_o | output | 1 | High in the cycle whose closing edge applies the hold and the bubble |

## Verification
The bound properties check four things at every edge:
- the hold of the three front registers after a stall,
- the zero bubble in execute,
- the plain advance when there is no stall,
- that a stall never lasts two cycles and never comes from a non-load opcode.

Whether the hazard test matches the right bit fields cannot be seen from these properties alone. The bench's instruction stream shows this with chosen register numbers:
- matches on the first source field and on the second,
- a near miss on bits 15:11,
- a load feeding another load's base,
- a non-load writer.

The bench alone also covers reset arriving in the middle of a stall.

// File: rtl/ldi_pkg.sv
package ldi_pkg;

    // Instruction geometry, bit numbers counted from the MSB side
    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 6;
    localparam int REG_W     = 5;
    localparam int NUM_SRC   = 2;
    localparam int OPC_LSB   = INSTR_W - OPC_W;
    localparam int SRC0_LSB  = OPC_LSB - REG_W;
    // The load destination shares the second source slot
    localparam int DST_LSB   = SRC0_LSB - REG_W;
    localparam int TAIL_W    = DST_LSB;

    localparam logic [OPC_W-1:0] LOAD_OPC = 6'b100011;

    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [REG_W-1:0]   reg_idx_t;

    typedef struct packed {
        logic [OPC_W-1:0]           opc;
        reg_idx_t [NUM_SRC-1:0]     src;
        reg_idx_t                   dst;
        logic [TAIL_W-1:0]          tail;
    } fields_t;

endpackage

// File: rtl/ldi_field_dec.sv
module ldi_field_dec
    import ldi_pkg::*;
(
    input  instr_t  instr_i,
    output fields_t fields_o,
    output logic    is_load_o
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign fields_o.src[k] = instr_i[SRC0_LSB - k*REG_W +: REG_W];
    end

    assign fields_o.opc  = instr_i[OPC_LSB +: OPC_W];
    assign fields_o.dst  = instr_i[DST_LSB +: REG_W];
    assign fields_o.tail = instr_i[TAIL_W-1:0];
    assign is_load_o     = (instr_i[OPC_LSB +: OPC_W] == LOAD_OPC);

endmodule

// File: rtl/ldi_hazard_cmp.sv
module ldi_hazard_cmp
    import ldi_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic                  load_vld_i,
    input  reg_idx_t              load_dst_i,
    input  reg_idx_t [N_SRC-1:0]  src_i,
    output logic                  hit_o
);

    logic [N_SRC-1:0] match;

    for (genvar k = 0; k < N_SRC; k++) begin : g_cmp
        assign match[k] = (src_i[k] == load_dst_i);
    end

    assign hit_o = load_vld_i && (|match);

endmodule

// File: rtl/ldi_interlock.sv
module ldi_interlock
    import ldi_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] pc_next_i,
    input  logic [ADDR_W-1:0] fd_npc_next_i,
    input  logic [31:0]       fd_ir_next_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] fd_npc_o,
    output logic [31:0]       fd_ir_o,
    output logic [31:0]       ex_ir_o,
    output logic              stall_o
);

    localparam instr_t BUBBLE = '0;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        instr_t            fd_ir;
        instr_t            ex_ir;
    } state_t;

    state_t  state_d, state_q;
    fields_t fd_fields, ex_fields;
    logic    fd_is_load, ex_is_load;
    logic    hazard;

    // Field extraction for both stages
    ldi_field_dec u_dec_fd (
        .instr_i   (state_q.fd_ir),
        .fields_o  (fd_fields),
        .is_load_o (fd_is_load)
    );

    ldi_field_dec u_dec_ex (
        .instr_i   (state_q.ex_ir),
        .fields_o  (ex_fields),
        .is_load_o (ex_is_load)
    );

    // Load destination against every decode source
    ldi_hazard_cmp #(.N_SRC(NUM_SRC)) u_cmp (
        .load_vld_i (ex_is_load),
        .load_dst_i (ex_fields.dst),
        .src_i      (fd_fields.src),
        .hit_o      (hazard)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (hazard) begin
            state_d.ex_ir = BUBBLE;
        end else begin
            state_d.pc    = pc_next_i;
            state_d.npc   = fd_npc_next_i;
            state_d.fd_ir = fd_ir_next_i;
            state_d.ex_ir = state_q.fd_ir;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o     = state_q.pc;
    assign fd_npc_o = state_q.npc;
    assign fd_ir_o  = state_q.fd_ir;
    assign ex_ir_o  = state_q.ex_ir;
    assign stall_o  = hazard;

endmodule

// File: rtl/ldi_checker.sv
module ldi_checker
    import ldi_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] pc_next_i,
    input logic [ADDR_W-1:0] fd_npc_next_i,
    input logic [31:0]       fd_ir_next_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] fd_npc_o,
    input logic [31:0]       fd_ir_o,
    input logic [31:0]       ex_ir_o,
    input logic              stall_o
);

    // R2: front registers frozen across a stall edge
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |=> ($stable(pc_o) && $stable(fd_npc_o) && $stable(fd_ir_o)));

    // R3: bubble lands in execute
    assert_bubble_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |=> (ex_ir_o == 32'h0));

    // R4: plain advance when no hazard
    assert_advance_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !stall_o |=> (ex_ir_o == $past(fd_ir_o) && pc_o == $past(pc_next_i)
                      && fd_npc_o == $past(fd_npc_next_i)
                      && fd_ir_o == $past(fd_ir_next_i)));

    // R5: never two stall cycles in a row
    assert_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |=> !stall_o);

    // R6: only a load can raise a stall
    assert_nonload_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ex_ir_o[OPC_LSB +: OPC_W] != LOAD_OPC) |-> !stall_o);

endmodule

bind ldi_interlock ldi_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .pc_next_i     (pc_next_i),
    .fd_npc_next_i (fd_npc_next_i),
    .fd_ir_next_i  (fd_ir_next_i),
    .pc_o          (pc_o),
    .fd_npc_o      (fd_npc_o),
    .fd_ir_o       (fd_ir_o),
    .ex_ir_o       (ex_ir_o),
    .stall_o       (stall_o)
);

// File: tb/ldi_interlock_tb.sv
`timescale 1ns/1ps
module ldi_interlock_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_in = '0, npc_in = '0, ir_in = '0;
    logic [31:0] pc_q, npc_q, fd_q, ex_q;
    logic        stall;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ldi_interlock #(.ADDR_W(32)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .pc_next_i     (pc_in),
        .fd_npc_next_i (npc_in),
        .fd_ir_next_i  (ir_in),
        .pc_o          (pc_q),
        .fd_npc_o      (npc_q),
        .fd_ir_o       (fd_q),
        .ex_ir_o       (ex_q),
        .stall_o       (stall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Row: instruction offered, expected decode IR, execute IR, stall flag after the edge
    typedef struct packed {
        logic [31:0] ir;
        logic [31:0] fd;
        logic [31:0] ex;
        logic        st;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{32'h8C410000, 32'h8C410000, 32'h00000000, 1'b0},  // load r1
        '{32'h00253000, 32'h00253000, 32'h8C410000, 1'b1},  // uses r1 in first source: stall
        '{32'h00672000, 32'h00253000, 32'h00000000, 1'b0},  // offered word ignored, bubble
        '{32'h00672000, 32'h00672000, 32'h00253000, 1'b0},  // held word advances
        '{32'h8C850000, 32'h8C850000, 32'h00672000, 1'b0},  // load r5
        '{32'h00451800, 32'h00451800, 32'h8C850000, 1'b1},  // uses r5 in second source: stall
        '{32'h00672000, 32'h00451800, 32'h00000000, 1'b0},
        '{32'h00672000, 32'h00672000, 32'h00451800, 1'b0},
        '{32'hAC230000, 32'hAC230000, 32'h00672000, 1'b0},  // non-load writes r3 slot
        '{32'h00610000, 32'h00610000, 32'hAC230000, 1'b0},  // reads r3: no stall
        '{32'h8C270000, 32'h8C270000, 32'h00610000, 1'b0},  // load r7
        '{32'h00433800, 32'h00433800, 32'h8C270000, 1'b0},  // r7 only in bits 15:11
        '{32'h8CE20000, 32'h8CE20000, 32'h00433800, 1'b0},  // load r2
        '{32'h8C440000, 32'h8C440000, 32'h8CE20000, 1'b1},  // load base r2: stall
        '{32'h00672000, 32'h8C440000, 32'h00000000, 1'b0},
        '{32'h00253000, 32'h00253000, 32'h8C440000, 1'b0}   // load r4 vs r1/r5: none
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_pc, exp_npc;
        logic        prev_st;

        repeat (3) @(negedge clk);
        // R7: state right after reset
        chk("R7 reset pc", pc_q, 32'h0);
        chk("R7 reset npc", npc_q, 32'h0);
        chk("R7 reset fd_ir", fd_q, 32'h0);
        chk("R7 reset ex_ir", ex_q, 32'h0);
        chk("R7 reset stall", {31'b0, stall}, 32'h0);
        rst = 1'b0;

        exp_pc  = '0;
        exp_npc = '0;
        prev_st = 1'b0;
        for (int k = 0; k < 16; k++) begin
            pc_in  = 32'h100 + 32'(k) * 4;
            npc_in = pc_in ^ 32'hFFFF_0000;
            ir_in  = VEC[k].ir;
            @(posedge clk);
            @(negedge clk);
            if (!prev_st) begin
                exp_pc  = pc_in;
                exp_npc = npc_in;
            end
            chk("R2/R4 decode ir", fd_q, VEC[k].fd);
            chk("R3/R4/R5 execute ir", ex_q, VEC[k].ex);
            chk("R1/R5/R6/R8 stall flag", {31'b0, stall}, {31'b0, VEC[k].st});
            chk("R2/R4 pc", pc_q, exp_pc);
            chk("R2/R4 next pc", npc_q, exp_npc);
            prev_st = VEC[k].st;
        end

        // R7: reset arriving while a stall is pending
        pc_in = 32'h200; npc_in = 32'h204; ir_in = 32'h8C410000;
        @(posedge clk); @(negedge clk);
        ir_in = 32'h00253000;
        @(posedge clk); @(negedge clk);
        chk("R1 stall before reset", {31'b0, stall}, 32'h1);
        rst = 1'b1;
        pc_in = 32'h300; npc_in = 32'h304; ir_in = 32'h00672000;
        @(posedge clk); @(negedge clk);
        chk("R7 mid-stall pc", pc_q, 32'h0);
        chk("R7 mid-stall npc", npc_q, 32'h0);
        chk("R7 mid-stall fd_ir", fd_q, 32'h0);
        chk("R7 mid-stall ex_ir", ex_q, 32'h0);
        chk("R7 mid-stall stall", {31'b0, stall}, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule